// File: doc/BRIEF.md
# Hybrid Sector Erase Resolver

This block turns one erase command for a serial NOR array into the erase that is to be performed. The array has a hybrid layout. A window of thirty-two small 4 KB sectors can be laid over one end of an array that is otherwise built from 64 KB sectors. The block takes an opcode, an address and an address-width flag. It applies two one-time configuration bits. The first removes the small-sector window. The second moves the window from the low end of the array to the high end. The block then consults the per-sector lock bits and returns one of three outcomes: an erase request (base address and size code), a command that is ignored, or a rejection that sets a sticky error flag.

Commands enter through a valid/ready handshake. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. Its result is held in an output register for as long as the consumer keeps `res_ready` low. While that result is held and not taken, `cmd_ready` stays low. This is the only back-pressure the block applies, and it never drops or reorders a command. The configuration port, the lock bits and the error-clear strobe are plain level or pulse signals.

Top module: `erase_resolver`

## Requirements
- R1: A command is taken on an edge with `cmd_valid` and `cmd_ready` high. Its result shows on the outputs with `res_valid` high from the next cycle on. The result stays unchanged while `res_ready` is low. `cmd_ready` equals `!res_valid || res_ready`, and `cmd_ready` is 1 and `res_valid` is 0 after reset.
- R2: Opcodes 20h and D8h use only `cmd_addr[23:0]` when `cmd_addr4` is 0 and the full address when it is 1. Opcodes 21h and DCh always use the full address. Address bits at and above `ARRAY_AW` are not decoded.
- R3: With the small-sector window enabled, a 20h or 21h command to an unlocked sector inside the window gives `erase_go`=1, `erase_size`=0 (4 KB) and `erase_base` equal to the address with bits [11:0] cleared.
- R4: A D8h or DCh command that is not refused gives `erase_go`=1, `erase_size`=1 (64 KB) and `erase_base` equal to the address with bits [15:0] cleared.
- R5: When the window is disabled (config bit 0 = 1), 20h and 21h give `ignored`=1 with no erase and no change to `err`. Any opcode other than 20h, 21h, D8h and DCh is also ignored.
- R6: With config bit 1 = 0, the window covers bytes 0 to 0x1FFFF. With config bit 1 = 1, it covers the top 128 KB of the 2^`ARRAY_AW`-byte array. Small sector n starts at window base + n*4 KB.
- R7: A config write (`cfg_wr`) ORs `cfg_wdata[1:0]` into the two config bits. A bit that has been set cannot be cleared by a later write. Both bits are 0 after reset.
- R8: A small sector counts as locked when its `lock_static` or `lock_dynamic` bit is 1. A 20h/21h command to a locked sector gives `rejected`=1 and no erase.
- R9: With the window enabled, a 64 KB erase whose block lies inside the window covers sixteen small sectors (group g = sectors 16g to 16g+15). If any of them is locked, the command gives `rejected`=1 and no erase.
- R10: A 20h/21h command whose address falls outside the enabled window gives `rejected`=1 and no erase.
- R11: `err` is 0 after reset. It becomes 1 in the cycle after a rejected command is taken and stays 1 until a `clear_err` pulse. If a rejection and a clear happen in the same cycle, the set wins.
- R12: With the window disabled, a 64 KB erase anywhere, including the former window, is performed regardless of the lock bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | One-cycle config write strobe |
| cfg_wdata | input | 2 | Bit 0: disable small-sector window; bit 1: place window at top |
| lock_static | input | 32 | Persistent lock bit per small sector |
| lock_dynamic | input | 32 | Volatile lock bit per small sector |
| clear_err | input | 1 | Clears the sticky error flag |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_opcode | input | 8 | Erase opcode |
| cmd_addr | input | 32 | Byte address |
| cmd_addr4 | input | 1 | 1 = 4-byte address mode for 20h/D8h |
| res_valid | output | 1 | Result held on outputs |
| res_ready | input | 1 | Consumer takes the result |
| erase_go | output | 1 | Erase to be performed |
| erase_base | output | 32 | Aligned base of the erase |
| erase_size | output | 1 | 0 = 4 KB, 1 = 64 KB |
| ignored | output | 1 | Command has no effect |
| rejected | output | 1 | Command refused |
| err | output | 1 | Sticky erase-error flag |

## Verification
The bench builds the block with `ARRAY_AW` = 26, a 64 MB array, and keeps the default of thirty-two small sectors in two groups. With this size the top-placed window sits at 0x3FE0000, beyond the 16 MB reach of 3-byte addressing. The same address therefore hits the window when `cmd_addr4` is 1 and is refused when it is 0, and the wide-only opcodes can be told apart from the mode-following ones. The two-group window lets one run show a 64 KB erase being refused in the group that holds a locked sector and accepted in the group that does not.

// File: rtl/erase_pkg.sv
package erase_pkg;

  localparam logic [7:0] OP_SMALL_MODE = 8'h20;
  localparam logic [7:0] OP_SMALL_WIDE = 8'h21;
  localparam logic [7:0] OP_LARGE_MODE = 8'hD8;
  localparam logic [7:0] OP_LARGE_WIDE = 8'hDC;

  typedef enum logic {
    SZ_SMALL = 1'b0,
    SZ_LARGE = 1'b1
  } erase_size_e;

  typedef struct packed {
    logic        go;
    logic [31:0] base;
    erase_size_e size;
    logic        ign;
    logic        rej;
  } erase_res_t;

endpackage

// File: rtl/erase_cfg_otp.sv
module erase_cfg_otp (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] wdata,
  output logic       win_off,
  output logic       win_top
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_off <= 1'b0;
      win_top <= 1'b0;
    end else if (wr) begin
      win_off <= win_off | wdata[0];
      win_top <= win_top | wdata[1];
    end
  end

endmodule

// File: rtl/erase_addr_map.sv
module erase_addr_map #(
  parameter int ARRAY_AW    = 25,
  parameter int NUM_SMALL   = 32,
  parameter int SMALL_SHIFT = 12,
  parameter int LARGE_SHIFT = 16,
  localparam int IDX_W      = $clog2(NUM_SMALL),
  localparam int WIN_SHIFT  = SMALL_SHIFT + IDX_W,
  localparam int GRP_W      = WIN_SHIFT - LARGE_SHIFT
) (
  input  logic [ARRAY_AW-1:0] addr,
  input  logic                wide,
  input  logic                win_top,
  output logic [ARRAY_AW-1:0] eff,
  output logic                in_window,
  output logic [IDX_W-1:0]    sector_idx,
  output logic [GRP_W-1:0]    group_idx
);

  localparam int TAG_W = ARRAY_AW - WIN_SHIFT;

  logic [TAG_W-1:0] tag;

  generate
    if (ARRAY_AW > 24) begin : g_narrow
      assign eff = wide ? addr : {{(ARRAY_AW-24){1'b0}}, addr[23:0]};
    end else begin : g_fits
      logic unused_wide;
      assign unused_wide = wide;
      assign eff         = addr;
    end
  endgenerate

  assign tag        = eff[ARRAY_AW-1:WIN_SHIFT];
  assign in_window  = win_top ? (&tag) : (tag == '0);
  assign sector_idx = eff[WIN_SHIFT-1:SMALL_SHIFT];
  assign group_idx  = eff[WIN_SHIFT-1:LARGE_SHIFT];

endmodule

// File: rtl/erase_lock_check.sv
module erase_lock_check #(
  parameter int NUM_SMALL   = 32,
  parameter int SMALL_SHIFT = 12,
  parameter int LARGE_SHIFT = 16,
  localparam int IDX_W      = $clog2(NUM_SMALL),
  localparam int PER_GRP    = 1 << (LARGE_SHIFT - SMALL_SHIFT),
  localparam int NUM_GRP    = NUM_SMALL / PER_GRP,
  localparam int GRP_W      = $clog2(NUM_GRP)
) (
  input  logic [NUM_SMALL-1:0] lock_a,
  input  logic [NUM_SMALL-1:0] lock_b,
  input  logic [IDX_W-1:0]     sector_idx,
  input  logic [GRP_W-1:0]     group_idx,
  output logic                 sector_locked,
  output logic                 group_locked
);

  logic [NUM_SMALL-1:0] locked;
  logic [NUM_GRP-1:0]   grp_any;

  assign locked = lock_a | lock_b;

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      assign grp_any[g] = |locked[g*PER_GRP +: PER_GRP];
    end
  endgenerate

  assign sector_locked = locked[sector_idx];
  assign group_locked  = grp_any[group_idx];

endmodule

// File: rtl/erase_resolver.sv
module erase_resolver #(
  parameter int ARRAY_AW    = 25,
  parameter int NUM_SMALL   = 32,
  parameter int SMALL_SHIFT = 12,
  parameter int LARGE_SHIFT = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [1:0]           cfg_wdata,
  input  logic [NUM_SMALL-1:0] lock_static,
  input  logic [NUM_SMALL-1:0] lock_dynamic,
  input  logic                 clear_err,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [7:0]           cmd_opcode,
  input  logic [31:0]          cmd_addr,
  input  logic                 cmd_addr4,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic                 erase_go,
  output logic [31:0]          erase_base,
  output logic                 erase_size,
  output logic                 ignored,
  output logic                 rejected,
  output logic                 err
);
  import erase_pkg::*;

  localparam int IDX_W = $clog2(NUM_SMALL);
  localparam int GRP_W = SMALL_SHIFT + IDX_W - LARGE_SHIFT;
  localparam logic [31:0] SMALL_MASK = ~((32'd1 << SMALL_SHIFT) - 32'd1);
  localparam logic [31:0] LARGE_MASK = ~((32'd1 << LARGE_SHIFT) - 32'd1);

  logic                param_off;
  logic                place_top;
  logic                wide;
  logic [ARRAY_AW-1:0] eff;
  logic [31:0]         eff32;
  logic                in_window;
  logic [IDX_W-1:0]    sector_idx;
  logic [GRP_W-1:0]    group_idx;
  logic                sector_locked;
  logic                group_locked;
  logic                accept;
  erase_res_t          nxt;
  erase_res_t          res_q;

  generate
    if (ARRAY_AW < 32) begin : g_hi
      logic unused_addr_hi;
      assign unused_addr_hi = ^cmd_addr[31:ARRAY_AW];
    end
  endgenerate

  erase_cfg_otp u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (cfg_wr),
    .wdata   (cfg_wdata),
    .win_off (param_off),
    .win_top (place_top)
  );

  assign wide = (cmd_opcode == OP_SMALL_WIDE) || (cmd_opcode == OP_LARGE_WIDE) || cmd_addr4;

  erase_addr_map #(
    .ARRAY_AW    (ARRAY_AW),
    .NUM_SMALL   (NUM_SMALL),
    .SMALL_SHIFT (SMALL_SHIFT),
    .LARGE_SHIFT (LARGE_SHIFT)
  ) u_map (
    .addr       (cmd_addr[ARRAY_AW-1:0]),
    .wide       (wide),
    .win_top    (place_top),
    .eff        (eff),
    .in_window  (in_window),
    .sector_idx (sector_idx),
    .group_idx  (group_idx)
  );

  erase_lock_check #(
    .NUM_SMALL   (NUM_SMALL),
    .SMALL_SHIFT (SMALL_SHIFT),
    .LARGE_SHIFT (LARGE_SHIFT)
  ) u_lock (
    .lock_a        (lock_static),
    .lock_b        (lock_dynamic),
    .sector_idx    (sector_idx),
    .group_idx     (group_idx),
    .sector_locked (sector_locked),
    .group_locked  (group_locked)
  );

  assign eff32 = 32'(eff);

  // Outcome of the offered command, decided before it is taken.
  always_comb begin
    nxt = '0;
    unique case (cmd_opcode)
      OP_SMALL_MODE, OP_SMALL_WIDE: begin
        if (param_off) begin
          nxt.ign = 1'b1;
        end else if (!in_window || sector_locked) begin
          nxt.rej = 1'b1;
        end else begin
          nxt.go   = 1'b1;
          nxt.base = eff32 & SMALL_MASK;
          nxt.size = SZ_SMALL;
        end
      end
      OP_LARGE_MODE, OP_LARGE_WIDE: begin
        if (!param_off && in_window && group_locked) begin
          nxt.rej = 1'b1;
        end else begin
          nxt.go   = 1'b1;
          nxt.base = eff32 & LARGE_MASK;
          nxt.size = SZ_LARGE;
        end
      end
      default: nxt.ign = 1'b1;
    endcase
  end

  assign cmd_ready = !res_valid || res_ready;
  assign accept    = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_q     <= '0;
    end else if (accept) begin
      res_valid <= 1'b1;
      res_q     <= nxt;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err <= 1'b0;
    end else if (accept && nxt.rej) begin
      err <= 1'b1;
    end else if (clear_err) begin
      err <= 1'b0;
    end
  end

  assign erase_go   = res_q.go;
  assign erase_base = res_q.base;
  assign erase_size = res_q.size;
  assign ignored    = res_q.ign;
  assign rejected   = res_q.rej;

endmodule

// File: rtl/erase_resolver_chk.sv
module erase_resolver_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        res_valid,
  input logic        res_ready,
  input logic        cmd_ready,
  input logic        erase_go,
  input logic [31:0] erase_base,
  input logic        erase_size,
  input logic        ignored,
  input logic        rejected,
  input logic        err,
  input logic        clear_err,
  input logic        param_off,
  input logic        place_top
);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(erase_base) && $stable(erase_go)
      && $stable(rejected) && $stable(ignored));

  assert_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !cmd_ready);

  assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $countones({erase_go, ignored, rejected}) == 1);

  assert_small_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && erase_go && !erase_size |-> erase_base[11:0] == 12'h0);

  assert_large_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && erase_go && erase_size |-> erase_base[15:0] == 16'h0);

  assert_otp_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    param_off |=> param_off);

  assert_otp_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
    place_top |=> place_top);

  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err && !clear_err |=> err);

endmodule

bind erase_resolver erase_resolver_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .cmd_ready  (cmd_ready),
  .erase_go   (erase_go),
  .erase_base (erase_base),
  .erase_size (erase_size),
  .ignored    (ignored),
  .rejected   (rejected),
  .err        (err),
  .clear_err  (clear_err),
  .param_off  (param_off),
  .place_top  (place_top)
);

// File: tb/erase_resolver_bench.sv
module erase_resolver_bench;

  localparam int AW = 26;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_wdata = 2'b00;
  logic [31:0] lock_static = '0;
  logic [31:0] lock_dynamic = '0;
  logic        clear_err = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_opcode = 8'h00;
  logic [31:0] cmd_addr = '0;
  logic        cmd_addr4 = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        erase_go;
  logic [31:0] erase_base;
  logic        erase_size;
  logic        ignored;
  logic        rejected;
  logic        err;

  int checks = 0;
  int fails = 0;
  logic m_off = 1'b0;
  logic m_top = 1'b0;
  logic [35:0] exp_q[$];
  string       tag_q[$];

  erase_resolver #(.ARRAY_AW(AW)) u_erase_resolver (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .lock_static(lock_static), .lock_dynamic(lock_dynamic), .clear_err(clear_err),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
    .cmd_addr(cmd_addr), .cmd_addr4(cmd_addr4), .res_valid(res_valid),
    .res_ready(res_ready), .erase_go(erase_go), .erase_base(erase_base),
    .erase_size(erase_size), .ignored(ignored), .rejected(rejected), .err(err)
  );

  always #4 clk = ~clk;

  // Expected outcome {go, base, size, ign, rej} from the requirements.
  function automatic logic [35:0] model(logic [7:0] op, logic [31:0] a, logic a4);
    logic        w;
    logic [31:0] ea, wb, prot;
    logic        inw, g, ign, rej, sz;
    logic [31:0] base;
    int          idx, grp;
    w    = (op == 8'h21) || (op == 8'hDC) || a4;
    ea   = w ? a : (a & 32'h00FF_FFFF);
    ea   = ea & ((32'd1 << AW) - 32'd1);
    wb   = m_top ? ((32'd1 << AW) - 32'h2_0000) : 32'd0;
    inw  = (ea >= wb) && (ea < wb + 32'h2_0000);
    idx  = int'((ea - wb) >> 12);
    grp  = idx / 16;
    prot = lock_static | lock_dynamic;
    g = 0; ign = 0; rej = 0; sz = 0; base = 0;
    if (op == 8'h20 || op == 8'h21) begin
      if (m_off) ign = 1;
      else if (!inw || prot[idx % 32]) rej = 1;
      else begin g = 1; base = {ea[31:12], 12'h0}; end
    end else if (op == 8'hD8 || op == 8'hDC) begin
      if (!m_off && inw && (((prot >> (grp * 16)) & 32'hFFFF) != 0)) rej = 1;
      else begin g = 1; sz = 1; base = {ea[31:16], 16'h0}; end
    end else ign = 1;
    return {g, base, sz, ign, rej};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic send(logic [7:0] op, logic [31:0] a, logic a4, string tag);
    logic r;
    @(posedge clk); #1;
    cmd_opcode = op; cmd_addr = a; cmd_addr4 = a4; cmd_valid = 1'b1;
    exp_q.push_back(model(op, a, a4));
    tag_q.push_back(tag);
    do begin
      @(negedge clk); r = cmd_ready;
      @(posedge clk); #1;
    end while (!r);
    cmd_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic cfg(logic [1:0] d);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
    m_off = m_off | d[0];
    m_top = m_top | d[1];
  endtask

  task automatic clr();
    @(posedge clk); #1 clear_err = 1'b1;
    @(posedge clk); #1 clear_err = 1'b0;
    @(negedge clk);
    check("R11 clear", 32'(err), 32'd0);
  endtask

  // Scoreboard monitor: compares each result as it is taken.
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R1: unexpected result base %h", erase_base);
      end else begin
        logic [35:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({erase_go, erase_base, erase_size, ignored, rejected} !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t,
                   {erase_go, erase_base, erase_size, ignored, rejected}, e);
        end
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset ready", 32'(cmd_ready), 32'd1);
    check("R1 reset valid", 32'(res_valid), 32'd0);
    check("R11 reset err", 32'(err), 32'd0);

    // Bottom window, unlocked.
    send(8'h20, 32'h0000_5123, 1'b0, "R3 small bottom");
    send(8'h21, 32'h0001_F0FF, 1'b0, "R2 R3 wide-only small");
    send(8'h20, 32'hFF00_3456, 1'b0, "R2 3-byte truncation");
    send(8'hD8, 32'h0004_1234, 1'b1, "R4 large outside window");
    send(8'hD8, 32'h0105_0000, 1'b0, "R2 R4 large 3-byte");
    drain();
    check("R11 no err yet", 32'(err), 32'd0);
    send(8'h20, 32'h0002_0000, 1'b0, "R10 small outside window");
    drain();
    check("R11 err set", 32'(err), 32'd1);
    clr();

    // Locks in the bottom window.
    @(posedge clk); #1 lock_dynamic = 32'h0010_0000; lock_static = 32'h0000_0008;
    send(8'hD8, 32'h0001_0000, 1'b0, "R9 group with locked sector");
    send(8'hD8, 32'h0000_0000, 1'b0, "R9 group with static lock");
    @(posedge clk); #1 lock_static = '0;
    send(8'hD8, 32'h0000_8000, 1'b0, "R9 clean group");
    send(8'h20, 32'h0001_4000, 1'b0, "R8 locked small sector");
    send(8'h03, 32'h0000_0000, 1'b0, "R5 unknown opcode");
    drain();
    check("R11 err after lock refusal", 32'(err), 32'd1);
    clr();

    // Window moved to the top.
    cfg(2'b10);
    send(8'h20, 32'h03FE_2000, 1'b1, "R6 top small 4-byte");
    send(8'h20, 32'h03FE_2000, 1'b0, "R2 R6 top small 3-byte");
    send(8'hDC, 32'h03FF_8000, 1'b0, "R9 top group locked");
    send(8'h20, 32'h0000_1000, 1'b0, "R6 bottom no longer window");
    @(posedge clk); #1 lock_dynamic = '0;
    send(8'hDC, 32'h03FF_8000, 1'b0, "R4 R9 top group clean");
    cfg(2'b00);
    send(8'h21, 32'h03FE_2000, 1'b0, "R7 top kept after clear try");
    drain();
    clr();

    // Uniform-only map.
    cfg(2'b01);
    @(posedge clk); #1 lock_dynamic = 32'hFFFF_FFFF;
    send(8'h20, 32'h03FE_2000, 1'b1, "R5 small ignored uniform");
    drain();
    check("R5 err untouched", 32'(err), 32'd0);
    send(8'hD8, 32'h03FF_0000, 1'b1, "R12 large ignores locks");
    cfg(2'b00);
    send(8'h21, 32'h03FE_0000, 1'b0, "R7 uniform kept");
    drain();
    check("R5 err still clear", 32'(err), 32'd0);

    // Back-pressure.
    @(posedge clk); #1 res_ready = 1'b0;
    send(8'hDC, 32'h0123_4567, 1'b0, "R1 stalled result");
    @(negedge clk);
    check("R1 valid held", 32'(res_valid), 32'd1);
    check("R1 ready low", 32'(cmd_ready), 32'd0);
    held = erase_base;
    repeat (3) @(negedge clk);
    check("R1 base stable", erase_base, held);
    @(posedge clk); #1 res_ready = 1'b1;
    drain();
    @(negedge clk);
    check("R1 valid drops", 32'(res_valid), 32'd0);

    finish_run();
  end

endmodule